// File: doc/BRIEF.md
# Line clamp pulse generator

This block produces one clamp pulse per video line. The pulse is timed from the trailing edge of the horizontal sync pulse. This is the moment the sync pulse ends, and it is used instead of its start. After that edge a programmable delay runs, and then the clamp output is driven high for a fixed number of clock cycles. A one-bit phase select picks a long delay or a short delay. A signal-present flag picks the pulse width: a normal width while a source is present, and a slightly longer fallback width when none is detected. The flag comes from elsewhere in the design.

All timing is given as clock-cycle parameters. The defaults assume a 100 MHz clock and a nominal line period of about 29.6 µs. With those defaults the delays are 1.0 µs (100 cycles) and 0.5 µs (50 cycles). The widths are 0.8 µs (80 cycles) normally and 0.9 µs (90 cycles) with no signal. The sync input, flag and select are taken to be synchronous to the clock. A parameter sets whether the sync pulse is active high or active low.

The controller has three states. `ST_IDLE` waits for a trailing edge. `ST_WAIT` counts the delay. `ST_DRIVE` holds the clamp high. The transitions are as follows:
- idle-to-wait on a trailing edge.
- wait-to-wait (restart) on a further trailing edge.
- wait-to-drive when the delay count expires.
- drive-to-wait (restart) on a trailing edge.
- drive-to-idle when the width count expires.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While reset is asserted and after it is released, `clamp` is 0 and the block stays in `ST_IDLE` until a trailing edge of the sync input is seen.
- R2: A trailing edge is a clock cycle in which the sync input is sampled inactive after being sampled active in the previous cycle. With the default active-high polarity this is a 1-to-0 change. Leading edges and steady levels, high or low, never start a pulse.
- R3: With `phase_sel` = 0 at the trailing edge, `clamp` rises `DLY_PH0` clock cycles (default 100) after the clock edge that samples the trailing edge.
- R4: With `phase_sel` = 1 at the trailing edge, `clamp` rises `DLY_PH1` clock cycles (default 50) after that edge.
- R5: With `sig_present` = 1 at the trailing edge, `clamp` stays high for exactly `WID_SIG` cycles (default 80).
- R6: With `sig_present` = 0 at the trailing edge, `clamp` stays high for exactly `WID_NOSIG` cycles (default 90).
- R7: `phase_sel` and `sig_present` are sampled only in the trailing-edge cycle. Changing them later does not alter the delay or width of the pulse already in progress.
- R8: A new trailing edge during the delay restarts the delay from zero, using the select and flag values of the new edge. No pulse is produced for the earlier edge.
- R9: A new trailing edge while `clamp` is high ends the pulse in the next cycle and starts a fresh delay.
- R10: Each trailing edge yields at most one pulse. After the width expires, `clamp` stays low until the next trailing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd | input | 1 | Horizontal sync pulse, polarity set by `HD_ACTIVE_HIGH` |
| sig_present | input | 1 | 1 when an input signal is detected; selects the pulse width |
| phase_sel | input | 1 | 0 selects the long delay, 1 the short delay |
| clamp | output | 1 | Clamp pulse, active high |

## Verification
The assertions check every cycle that the timer loads and counts down correctly, and that two trailing edges are never detected back to back. They also check that each trailing edge forces the waiting state and cuts off any pulse in progress. In the same way they check that an expired delay raises the clamp, that an expired width drops it, and that no pulse ever outlasts the longer width. The exact cycle at which the clamp rises and its exact length under each select and flag setting can only be shown by the bench's scenarios. The same holds for the insensitivity to mid-line changes of those inputs and the restart behaviour.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRIVE = 2'd2
    } clamp_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clamp_hd_edge.sv
module clamp_hd_edge #(
    parameter bit HD_ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hd,
    output logic trail
);

    logic hd_act;
    logic act_q;

    generate
        if (HD_ACTIVE_HIGH) begin : g_pos
            assign hd_act = hd;
        end else begin : g_neg
            assign hd_act = ~hd;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= hd_act;
        end
    end

    assign trail = act_q & ~hd_act;

    // R2
    trail_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> !trail);

endmodule

// File: rtl/clamp_timer.sv
module clamp_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // R5
    count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/clamp_fsm.sv
module clamp_fsm
    import clamp_pkg::*;
#(
    parameter int unsigned DLY_PH0   = 100,
    parameter int unsigned DLY_PH1   = 50,
    parameter int unsigned WID_SIG   = 80,
    parameter int unsigned WID_NOSIG = 90,
    parameter int unsigned CW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trail,
    input  logic          phase_sel,
    input  logic          sig_present,
    input  logic          zero,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          clamp
);

    localparam logic [CW-1:0] LD_PH0   = CW'(DLY_PH0 - 1);
    localparam logic [CW-1:0] LD_PH1   = CW'(DLY_PH1 - 1);
    localparam logic [CW-1:0] LD_SIG   = CW'(WID_SIG - 1);
    localparam logic [CW-1:0] LD_NOSIG = CW'(WID_NOSIG - 1);

    clamp_state_e state, state_nx;
    logic         nosig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nosig_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (trail) begin
                nosig_q <= ~sig_present;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (trail) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (trail)     state_nx = ST_WAIT;
                else if (zero) state_nx = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (trail)     state_nx = ST_WAIT;
                else if (zero) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        load_val = '0;
        clamp    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clamp = 1'b0;
            end
            ST_WAIT: begin
                clamp = 1'b0;
                if (!trail && zero) begin
                    load     = 1'b1;
                    load_val = nosig_q ? LD_NOSIG : LD_SIG;
                end
            end
            ST_DRIVE: begin
                clamp = 1'b1;
            end
            default: clamp = 1'b0;
        endcase
        if (trail) begin
            load     = 1'b1;
            load_val = phase_sel ? LD_PH1 : LD_PH0;
        end
    end

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> (state == ST_WAIT));

    // R9
    cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRIVE && trail) |=> !clamp);

    // R3
    rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && zero && !trail) |=> clamp);

    // R10
    end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRIVE && zero && !trail) |=> (state == ST_IDLE));

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import clamp_pkg::*;
#(
    parameter int unsigned DLY_PH0        = 100,
    parameter int unsigned DLY_PH1        = 50,
    parameter int unsigned WID_SIG        = 80,
    parameter int unsigned WID_NOSIG      = 90,
    parameter bit          HD_ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hd,
    input  logic sig_present,
    input  logic phase_sel,
    output logic clamp
);

    localparam int unsigned DMAX = max2(DLY_PH0, DLY_PH1);
    localparam int unsigned WMAX = max2(WID_SIG, WID_NOSIG);
    localparam int unsigned CMAX = max2(DMAX, WMAX);
    localparam int unsigned CW   = $clog2(CMAX + 1);

    logic          trail;
    logic          load;
    logic [CW-1:0] load_val;
    logic          zero;

    clamp_hd_edge #(
        .HD_ACTIVE_HIGH(HD_ACTIVE_HIGH)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .hd    (hd),
        .trail (trail)
    );

    clamp_timer #(
        .CW(CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .zero     (zero)
    );

    clamp_fsm #(
        .DLY_PH0   (DLY_PH0),
        .DLY_PH1   (DLY_PH1),
        .WID_SIG   (WID_SIG),
        .WID_NOSIG (WID_NOSIG),
        .CW        (CW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trail       (trail),
        .phase_sel   (phase_sel),
        .sig_present (sig_present),
        .zero        (zero),
        .load        (load),
        .load_val    (load_val),
        .clamp       (clamp)
    );

    logic [CW:0] hi_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= '0;
        end else if (clamp) begin
            hi_len <= hi_len + 1'b1;
        end else begin
            hi_len <= '0;
        end
    end

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len <= (CW+1)'(WMAX));

endmodule

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;

    localparam int D0 = 100;
    localparam int D1 = 50;
    localparam int WS = 80;
    localparam int WN = 90;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hd = 1'b0;
    logic sig_present = 1'b1;
    logic phase_sel = 1'b0;
    logic clamp;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    clamp_pulse_gen #(
        .DLY_PH0(D0), .DLY_PH1(D1), .WID_SIG(WS), .WID_NOSIG(WN), .HD_ACTIVE_HIGH(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hd(hd), .sig_present(sig_present),
        .phase_sel(phase_sel), .clamp(clamp)
    );

    function automatic int exp_delay(input bit ph);
        return ph ? D1 : D0;
    endfunction

    function automatic int exp_width(input bit sp);
        return sp ? WS : WN;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; hd active for hi cycles, then released
    task automatic drive_fall(input int hi);
        hd = 1'b1;
        repeat (hi) @(negedge clk);
        hd = 1'b0;
    endtask

    // counts negedges after the release until clamp is seen high
    task automatic wait_rise(input bit flip, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (flip && k == 2) begin
                phase_sel   = ~phase_sel;
                sig_present = ~sig_present;
            end
        end while (!clamp && k < 2000);
    endtask

    task automatic measure_len(output int len);
        len = 1;
        @(negedge clk);
        while (clamp && len < 2000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clamp) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic one_line(input bit ph, input bit sp, input int hi, input bit flip);
        int k;
        int len;
        phase_sel   = ph;
        sig_present = sp;
        drive_fall(hi);
        wait_rise(flip, k);
        chk(k == exp_delay(ph) + 1, flip ? "R7 delay" : (ph ? "R4" : "R3"), k, exp_delay(ph) + 1);
        measure_len(len);
        chk(len == exp_width(sp), flip ? "R7 width" : (sp ? "R5" : "R6"), len, exp_width(sp));
        quiet(15, "R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        int k;
        int len;
        seed_init = $urandom(32'h0000C1A4);

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(clamp == 1'b0, "R1 in reset", int'(clamp), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clamp == 1'b0, "R1 after reset", int'(clamp), 0);

        // R2: steady low, then leading edge and steady high
        quiet(200, "R2 low");
        hd = 1'b1;
        quiet(200, "R2 high");
        hd = 1'b0;
        wait_rise(1'b0, k);
        chk(k == D0 + 1, "R2 trailing edge R3", k, D0 + 1);
        measure_len(len);
        chk(len == WS, "R5", len, WS);
        quiet(20, "R10");

        // directed settings
        one_line(1'b0, 1'b1, 3, 1'b0);
        one_line(1'b1, 1'b1, 1, 1'b0);
        one_line(1'b0, 1'b0, 5, 1'b0);
        one_line(1'b1, 1'b0, 2, 1'b0);
        one_line(1'b0, 1'b1, 4, 1'b1);
        one_line(1'b1, 1'b0, 4, 1'b1);

        // R8: restart during the delay
        phase_sel = 1'b0;
        sig_present = 1'b1;
        drive_fall(3);
        quiet(30, "R8 no early pulse");
        phase_sel = 1'b1;
        sig_present = 1'b0;
        drive_fall(1);
        wait_rise(1'b0, k);
        chk(k == D1 + 1, "R8 restart delay", k, D1 + 1);
        measure_len(len);
        chk(len == WN, "R8 restart width", len, WN);
        quiet(20, "R10");

        // R9: new trailing edge while clamp is high
        phase_sel = 1'b1;
        sig_present = 1'b1;
        drive_fall(2);
        wait_rise(1'b0, k);
        chk(k == D1 + 1, "R4", k, D1 + 1);
        repeat (10) @(negedge clk);
        chk(clamp == 1'b1, "R9 mid pulse", int'(clamp), 1);
        phase_sel = 1'b0;
        sig_present = 1'b0;
        drive_fall(1);
        wait_rise(1'b0, k);
        chk(k == D0 + 1, "R9 cut and restart", k, D0 + 1);
        measure_len(len);
        chk(len == WN, "R9 new width", len, WN);
        quiet(20, "R10");

        // constrained random lines
        for (int it = 0; it < 40; it++) begin
            bit ph;
            bit sp;
            bit fl;
            int hi;
            ph = 1'($urandom());
            sp = 1'($urandom());
            fl = ($urandom_range(3, 0) == 0);
            hi = int'($urandom_range(16, 1));
            repeat ($urandom_range(30, 0)) @(negedge clk);
            one_line(ph, sp, hi, fl);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule